// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector

This block watches the clock and data lines of a two-wire serial bus from inside a synchronous system. Both lines are sampled with the system clock and passed through a glitch filter before any edge is detected. From the cleaned lines it produces single-cycle pulses for bus start, bus stop, and the rising and falling edges of the bus clock. It also provides the filtered levels of both lines, so the data bit can be taken at a clock edge. The rest of a bus slave (address match, byte shifting, acknowledge, memory access) uses these pulses. A start or stop pulse is the signal that returns that logic to its idle state.

Each line goes through a two-flop synchroniser and then a counting filter. The filtered level moves to a new value only after `FILT_LEN` consecutive system-clock samples agree on that value. A pulse narrower than the filter window therefore never reaches the edge logic. The window is set with `FILT_LEN` to cover the required suppression time, for example 50 ns or 100 ns depending on the supply range. Start and stop are decided by how the filtered data line moves, judged against the filtered clock level from the cycle before that movement.

Top module: `tw_cond_detect`

## Requirements
- R1: When the filtered data line goes from 1 to 0 and the filtered clock line was 1 in the previous cycle, `start_o` pulses high for exactly one cycle.
- R2: When the filtered data line goes from 0 to 1 and the filtered clock line was 1 in the previous cycle, `stop_o` pulses high for exactly one cycle.
- R3: A 0-to-1 move of the filtered clock line gives a one-cycle `scl_rise_o`. A 1-to-0 move gives a one-cycle `scl_fall_o`. Neither pulse occurs in the same cycle as the other, and `start_o` and `stop_o` never occur in the same cycle.
- R4: A data-line change made while the clock line is low produces no start or stop. `sda_o` takes the new level once the line has been stable long enough.
- R5: A level change on either line that lasts fewer than `FILT_LEN` consecutive system-clock samples is ignored. The filtered level does not move and no event pulse appears.
- R6: A change held for at least `FILT_LEN` samples is accepted. With the input changed between clock edges, the filtered output and its event pulse appear right after the (`FILT_LEN`+2)-th rising system-clock edge that follows the change. Between two accepted moves of one filtered line there are at least `FILT_LEN` cycles.
- R7: During and right after reset, `scl_o` and `sda_o` read 1 and no event pulse appears while both lines stay high.
- R8: If the clock line falls and the data line rises within the same filtered cycle, the block reports a stop together with a clock fall. If the clock line rises and the data line falls within the same filtered cycle, it reports only a clock rise and no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| scl_o | output | 1 | Filtered bus clock level |
| sda_o | output | 1 | Filtered bus data level (the data bit) |
| start_o | output | 1 | One-cycle start pulse |
| stop_o | output | 1 | One-cycle stop pulse |
| scl_rise_o | output | 1 | One-cycle pulse on filtered clock rising |
| scl_fall_o | output | 1 | One-cycle pulse on filtered clock falling |

## Verification
The bound checker checks on every cycle the rules that can be seen at the outputs:
- start and stop follow the right movement of the filtered data line with the clock high in the previous cycle;
- clock-edge pulses match the movement of `scl_o`;
- paired pulses are exclusive;
- each filtered line keeps at least `FILT_LEN` cycles between moves;
- the idle level holds after reset.

Some behaviours depend on the raw input waveform, and only the bench scenarios show them: glitches just under the window being rejected, a pulse of exactly the window length being accepted, the exact input-to-output latency, and the ordering of simultaneous clock and data moves. The bench checks them against a queue of expected events.

// File: rtl/tw_cond_pkg.sv
// Package: shared types for the two-wire bus condition detector.
// Assumes nothing beyond a single system clock domain for its users.
package tw_cond_pkg;

    // One-cycle bus event flags produced by the decoder.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } tw_evt_t;

    // Index of each bus line in the filter array.
    localparam int unsigned LINE_SCL  = 0;
    localparam int unsigned LINE_SDA  = 1;
    localparam int unsigned NUM_LINES = 2;

endpackage

// File: rtl/tw_line_filter.sv
// Module: tw_line_filter
// Brings one asynchronous bus line into the clock domain through a
// SYNC_STAGES-deep flop chain, then applies a counting filter: the output
// level takes a new value only after FILT_LEN consecutive synchronised
// samples differ from it. Assumes SYNC_STAGES >= 2 and FILT_LEN >= 1.
// The output resets high, matching an idle pulled-up bus line.
module tw_line_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   level_q;
    logic                   sample;

    assign sample  = sync_q[SYNC_STAGES-1];
    assign level_o = level_q;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // Count consecutive disagreeing samples; adopt the new level at FILT_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_q <= 1'b1;
        end else if (sample == level_q) begin
            run_q <= '0;
        end else if (run_q == CNT_LAST) begin
            run_q   <= '0;
            level_q <= sample;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/tw_event_decode.sv
// Module: tw_event_decode
// Turns the filtered clock and data levels into one-cycle event flags.
// Start and stop are judged with the clock level held from the previous
// cycle, so a clock move in the same cycle as a data move does not change
// the verdict. Assumes both inputs are already filtered and synchronous.
module tw_event_decode
    import tw_cond_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_f,
    input  logic    sda_f,
    output tw_evt_t evt_o
);
    logic scl_q;
    logic sda_q;

    // Hold the previous filtered levels; idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Compare current and previous levels to form the event flags.
    always_comb begin
        evt_o.start    = scl_q &  sda_q & ~sda_f;
        evt_o.stop     = scl_q & ~sda_q &  sda_f;
        evt_o.scl_rise = ~scl_q &  scl_f;
        evt_o.scl_fall =  scl_q & ~scl_f;
    end
endmodule

// File: rtl/tw_cond_detect.sv
// Module: tw_cond_detect (top)
// Filters the two bus lines and reports start, stop and clock edges as
// one-cycle pulses, along with the filtered line levels. Assumes the
// system clock is fast enough that FILT_LEN cycles cover the required
// glitch suppression time and stay well below a bus clock half period.
module tw_cond_detect
    import tw_cond_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] filt_lines;
    tw_evt_t              evt;

    assign raw_lines[LINE_SCL] = scl_i;
    assign raw_lines[LINE_SDA] = sda_i;

    // One synchroniser and filter per bus line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        tw_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .level_o(filt_lines[g])
        );
    end

    tw_event_decode dec_i (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_f(filt_lines[LINE_SCL]),
        .sda_f(filt_lines[LINE_SDA]),
        .evt_o(evt)
    );

    assign scl_o      = filt_lines[LINE_SCL];
    assign sda_o      = filt_lines[LINE_SDA];
    assign start_o    = evt.start;
    assign stop_o     = evt.stop;
    assign scl_rise_o = evt.scl_rise;
    assign scl_fall_o = evt.scl_fall;
endmodule

// File: rtl/tw_cond_detect_chk.sv
// Module: tw_cond_detect_chk
// Checker bound to tw_cond_detect. It watches only the top-level ports
// and keeps its own history and gap counters for the filtered lines.
module tw_cond_detect_chk #(
    parameter int unsigned FILT_LEN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic scl_o,
    input logic sda_o,
    input logic start_o,
    input logic stop_o,
    input logic scl_rise_o,
    input logic scl_fall_o
);
    localparam int unsigned GW = $clog2(FILT_LEN + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(FILT_LEN);
    localparam logic [GW-1:0] GAP_MIN = GW'(FILT_LEN - 1);

    logic          scl_h, sda_h;
    logic [GW-1:0] scl_gap, sda_gap;
    logic          scl_mv, sda_mv;

    assign scl_mv = scl_o != scl_h;
    assign sda_mv = sda_o != sda_h;

    // Track previous filtered levels and cycles since each line last moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_h   <= 1'b1;
            sda_h   <= 1'b1;
            scl_gap <= '0;
            sda_gap <= '0;
        end else begin
            scl_h   <= scl_o;
            sda_h   <= sda_o;
            scl_gap <= scl_mv ? '0 : ((scl_gap == GAP_MAX) ? scl_gap : scl_gap + 1'b1);
            sda_gap <= sda_mv ? '0 : ((sda_gap == GAP_MAX) ? sda_gap : sda_gap + 1'b1);
        end
    end

    // R1
    start_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (!sda_o && sda_h && $past(scl_o)));
    // R2
    stop_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (sda_o && !sda_h && $past(scl_o)));
    // R3
    scl_rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_o |-> (scl_o && !scl_h));
    // R3
    scl_fall_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_o |-> (!scl_o && scl_h));
    // R3
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise_o, scl_fall_o}) && $onehot0({start_o, stop_o}));
    // R6
    scl_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_mv |-> (scl_gap >= GAP_MIN));
    // R6
    sda_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_mv |-> (sda_gap >= GAP_MIN));
    // R7
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (scl_o && sda_o && !start_o && !stop_o && !scl_rise_o && !scl_fall_o));
endmodule

bind tw_cond_detect tw_cond_detect_chk #(.FILT_LEN(FILT_LEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_o     (scl_o),
    .sda_o     (sda_o),
    .start_o   (start_o),
    .stop_o    (stop_o),
    .scl_rise_o(scl_rise_o),
    .scl_fall_o(scl_fall_o)
);

// File: tb/tw_cond_detect_tb_top.sv
// Bench: a scoreboard for tw_cond_detect. Driver tasks push the events the
// requirements predict, and a monitor pops and compares them as pulses appear.
module tw_cond_detect_tb_top;
    localparam int unsigned N      = 5;
    localparam int unsigned SETTLE = N + 8;

    typedef enum int { EV_START, EV_STOP, EV_RISE, EV_FALL } ev_e;
    typedef struct {
        ev_e   kind;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_i = 1'b1;
    logic sda_i = 1'b1;
    logic scl_o, sda_o, start_o, stop_o, scl_rise_o, scl_fall_o;

    int   total = 0;
    int   bad   = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    tw_cond_detect #(.SYNC_STAGES(2), .FILT_LEN(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_o), .sda_o(sda_o), .start_o(start_o), .stop_o(stop_o),
        .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o)
    );

    // Record one check and report a mismatch.
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Compare one observed pulse against the head of the scoreboard.
    task automatic pop_cmp(input ev_e got);
        exp_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R5", "unexpected event", int'(got), -1);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == got, e.req, "event kind", int'(got), int'(e.kind));
        end
    endtask

    // Monitor: sample pulses on the falling edge, in a fixed order.
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_o)    pop_cmp(EV_START);
            if (stop_o)     pop_cmp(EV_STOP);
            if (scl_rise_o) pop_cmp(EV_RISE);
            if (scl_fall_o) pop_cmp(EV_FALL);
        end
    end

    task automatic push(input ev_e k, input string req);
        exp_t e;
        e.kind = k;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    // Drive both lines together and predict events from the requirements.
    task automatic bus_set(input logic nscl, input logic nsda, input string req);
        if (scl_i && sda_i && !nsda)  push(EV_START, req);
        if (scl_i && !sda_i && nsda)  push(EV_STOP, req);
        if (!scl_i && nscl)           push(EV_RISE, req);
        if (scl_i && !nscl)           push(EV_FALL, req);
        @(negedge clk);
        scl_i = nscl;
        sda_i = nsda;
        repeat (SETTLE) @(negedge clk);
    endtask

    // Pulse one line to the opposite level for len cycles, then restore it.
    task automatic pulse_line(input bit is_scl, input int len);
        @(negedge clk);
        if (is_scl) scl_i = ~scl_i; else sda_i = ~sda_i;
        repeat (len) @(negedge clk);
        if (is_scl) scl_i = ~scl_i; else sda_i = ~sda_i;
        repeat (SETTLE) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R7: idle-high levels while reset is held
        chk(scl_o === 1'b1 && sda_o === 1'b1, "R7", "levels in reset", {scl_o, sda_o}, 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_o === 1'b1 && sda_o === 1'b1, "R7", "levels after reset", {scl_o, sda_o}, 3);
        chk({start_o, stop_o, scl_rise_o, scl_fall_o} == 4'b0, "R7", "no pulse after reset",
            {start_o, stop_o, scl_rise_o, scl_fall_o}, 0);
        repeat (SETTLE) @(negedge clk);

        // R1: start
        bus_set(1'b1, 1'b0, "R1");
        // R3: clock fall
        bus_set(1'b0, 1'b0, "R3");
        // R4: data change while clock low
        bus_set(1'b0, 1'b1, "R4");
        chk(sda_o === 1'b1, "R4", "sda_o after low-clock change", sda_o, 1);
        bus_set(1'b1, 1'b1, "R3");
        bus_set(1'b0, 1'b1, "R3");
        bus_set(1'b0, 1'b0, "R4");
        chk(sda_o === 1'b0, "R4", "sda_o follows data", sda_o, 0);
        bus_set(1'b1, 1'b0, "R3");
        // R2: stop
        bus_set(1'b1, 1'b1, "R2");

        // R5: glitches one cycle under the window on each line
        pulse_line(1'b1, N - 1);
        chk(scl_o === 1'b1, "R5", "scl_o after short glitch", scl_o, 1);
        pulse_line(1'b0, N - 1);
        chk(sda_o === 1'b1, "R5", "sda_o after short glitch", sda_o, 1);
        pulse_line(1'b0, 1);
        chk(sda_o === 1'b1, "R5", "sda_o after 1-cycle glitch", sda_o, 1);

        // R6: exactly-window pulse on the clock line is accepted
        push(EV_FALL, "R6");
        push(EV_RISE, "R6");
        pulse_line(1'b1, N);
        chk(scl_o === 1'b1, "R6", "scl_o after window pulse", scl_o, 1);

        // R6: latency of an accepted move
        push(EV_FALL, "R6");
        @(negedge clk);
        scl_i = 1'b0;
        repeat (N + 1) @(posedge clk);
        @(negedge clk);
        chk(scl_o === 1'b1, "R6", "scl_o one edge early", scl_o, 1);
        @(posedge clk);
        @(negedge clk);
        chk(scl_o === 1'b0, "R6", "scl_o at latency", scl_o, 0);
        repeat (SETTLE) @(negedge clk);
        bus_set(1'b1, 1'b1, "R3");

        // R8: clock falls as data rises -> stop plus fall
        bus_set(1'b1, 1'b0, "R1");
        bus_set(1'b0, 1'b1, "R8");
        // R8: clock rises as data falls -> rise only
        bus_set(1'b1, 1'b0, "R8");
        chk(scl_o === 1'b1 && sda_o === 1'b0, "R8", "levels after joint move",
            {scl_o, sda_o}, 2);
        bus_set(1'b1, 1'b1, "R2");

        repeat (SETTLE) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "events still expected", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule